// File: doc/BRIEF.md
# Ordered Shadow-to-Always-On Register Update Sequencer

This block sits between a fast bus-side register bank and the copies of those registers that live in a slow, always-on domain. Eight words are managed: six general persistent words (indices 0 to 5), an alarm word (index 6) and a seconds word (index 7). A bus write lands in the fast-side shadow word at once and flags that word as out of date. A single-lane sequencer then moves out-of-date words across one at a time. It always takes the lowest-numbered flagged word next, so the seconds word is moved last.

Software watches a status word to learn when its data has arrived. It holds one bit per register that says the copy is still pending, and one bit per register that says the copy has been refreshed. The crossing into the slow domain is modelled as a fixed, parameterised number of cycles per transfer. A read-back port returns the slow-domain copy of any word, so the results can be seen at the block's edge.

Top module: `upd_shadow_seq`

## Requirements
- R1: After a synchronous reset, `status` is zero, `busy` is low, and every slow-domain copy reads zero, which equals the reset value of the shadow words.
- R2: A write with `wr_en` high and index `wr_sel` sets that register's pending bit on the clock edge that samples the write. The pending bits sit at `status[23:16]`, and bit i belongs to register i (bits 0..5 persistent words, bit 6 alarm, bit 7 seconds, so seconds is mask 0x80 within the field).
- R3: Only one transfer is in flight at any time, so no two pending bits ever clear on the same edge.
- R4: When no transfer is active and any pending bit is set, the next transfer starts on the following edge with the lowest-numbered pending register.
- R5: A transfer lasts `XFER_CYCLES` cycles (default 4) after the edge that starts it. A write into an idle block therefore clears its pending bit on the (`XFER_CYCLES`+1)th edge after the write edge.
- R6: Writing a register again while its pending bit is set does not queue a second transfer. The one transfer carries the most recent value.
- R7: The refreshed bits sit at `status[15:8]` in the same order as the pending bits. A bit sets on the edge its copy lands and stays set until a cycle with `stat_rd` high clears the field. A landing in that same cycle wins over the clear.
- R8: `busy` is high exactly while any pending bit is set.
- R9: After a transfer lands, the slow copy equals the latest shadow value. `slow_rd_data` returns the copy addressed by `slow_rd_sel` one cycle after that index is presented.
- R10: With no further writes, `busy` falls no more than `NUM_REGS`*(`XFER_CYCLES`+1) cycles after the last write.
- R11: A write to the register under transfer, sampled on the very edge its copy lands, leaves the pending bit set. A further transfer then carries the newer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe for the shadow bank |
| wr_sel | input | 3 | Register index of the write |
| wr_data | input | 32 | Write data |
| stat_rd | input | 1 | Status read strobe; clears the refreshed field |
| slow_rd_sel | input | 3 | Index of the slow-domain copy to read back |
| status | output | 32 | Pending field at 23:16, refreshed field at 15:8, other bits zero |
| busy | output | 1 | High while any register is pending |
| slow_rd_data | output | 32 | Registered slow-domain copy selected by `slow_rd_sel` |

## Verification
The bench first writes a burst of registers in scrambled order. The first register written must go first, because it is picked before the rest arrive. The remainder must then go lowest index first. A sequencer that picked highest-first or in write order would pop the wrong index from the scoreboard. One register is rewritten inside the burst: a design that queued a repeat would produce an unexpected extra transfer, and one that latched the early value would return stale slow-copy data. A write aimed at the exact landing edge shows whether the landing is allowed to wrongly erase the new pending flag. The bench also samples the pending bit one cycle before and one cycle after the landing edge, which catches off-by-one transfer timing. Finally, a landing that coincides with a status read shows whether the clear is allowed to wrongly swallow a fresh refreshed bit.

// File: rtl/upd_seq_pkg.sv
package upd_seq_pkg;

  // Worst-case number of cycles for a fully pending bank to drain.
  function automatic int unsigned drain_bound(input int unsigned n_regs,
                                              input int unsigned xfer);
    return n_regs * (xfer + 1);
  endfunction

endpackage

// File: rtl/upd_pick.sv
// Lowest-index request picker.
module upd_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/upd_xfer_timer.sv
// Models the domain-crossing latency of one transfer.
module upd_xfer_timer #(
  parameter int CYCLES = 4,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end
  end

  assign done = active && (cnt_q == '0);
endmodule

// File: rtl/upd_flag_bank.sv
// Pending and refreshed flag registers.
module upd_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] land_vec,
  input  logic         clr_new,
  output logic [N-1:0] stale,
  output logic [N-1:0] fresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stale <= '0;
      fresh <= '0;
    end else begin
      // a write on the landing edge keeps the register pending
      stale <= (stale & ~land_vec) | set_vec;
      // a landing beats a concurrent clear
      fresh <= (clr_new ? '0 : fresh) | land_vec;
    end
  end
endmodule

// File: rtl/upd_shadow_seq.sv
module upd_shadow_seq #(
  parameter int NUM_REGS    = 8,
  parameter int DATA_W      = 32,
  parameter int XFER_CYCLES = 4,
  parameter int STAT_W      = 32,
  parameter int STALE_LSB   = 16,
  parameter int NEW_LSB     = 8,
  localparam int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic [IDX_W-1:0]  slow_rd_sel,
  output logic [STAT_W-1:0] status,
  output logic              busy,
  output logic [DATA_W-1:0] slow_rd_data
);
  logic [DATA_W-1:0] shadow_mem [NUM_REGS];
  logic [DATA_W-1:0] slow_mem   [NUM_REGS];

  logic [NUM_REGS-1:0] stale_q, fresh_q, set_vec, land_vec;
  logic [IDX_W-1:0]    pick_idx, cur_q;
  logic                pick_any, xfer_active, xfer_done, start;

  upd_pick #(.N(NUM_REGS), .IDX_W(IDX_W)) u_pick (
    .req (stale_q),
    .idx (pick_idx),
    .any (pick_any)
  );

  assign start = pick_any && !xfer_active;

  upd_xfer_timer #(.CYCLES(XFER_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .active (xfer_active),
    .done   (xfer_done)
  );

  always_ff @(posedge clk) begin
    if (rst)        cur_q <= '0;
    else if (start) cur_q <= pick_idx;
  end

  always_comb begin
    set_vec  = '0;
    land_vec = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (wr_en && (wr_sel == IDX_W'(i)))    set_vec[i]  = 1'b1;
      if (xfer_done && (cur_q == IDX_W'(i))) land_vec[i] = 1'b1;
    end
  end

  upd_flag_bank #(.N(NUM_REGS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .land_vec (land_vec),
    .clr_new  (stat_rd),
    .stale    (stale_q),
    .fresh    (fresh_q)
  );

  // Fast-side shadow bank and slow-side copies.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        shadow_mem[i] <= '0;
        slow_mem[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (set_vec[i])  shadow_mem[i] <= wr_data;
        if (land_vec[i]) slow_mem[i]   <= shadow_mem[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) slow_rd_data <= '0;
    else     slow_rd_data <= slow_mem[slow_rd_sel];
  end

  always_comb begin
    status = '0;
    status[STALE_LSB +: NUM_REGS] = stale_q;
    status[NEW_LSB   +: NUM_REGS] = fresh_q;
  end

  assign busy = |stale_q;
endmodule

// File: rtl/upd_shadow_seq_chk.sv
module upd_shadow_seq_chk #(
  parameter int NUM_REGS    = 8,
  parameter int XFER_CYCLES = 4,
  parameter int STAT_W      = 32,
  parameter int STALE_LSB   = 16,
  parameter int NEW_LSB     = 8,
  parameter int IDX_W       = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_sel,
  input logic              stat_rd,
  input logic [STAT_W-1:0] status,
  input logic              busy
);
  localparam int BOUND = int'(upd_seq_pkg::drain_bound(NUM_REGS, XFER_CYCLES));
  localparam int CW    = $clog2(BOUND + 2);

  logic [NUM_REGS-1:0] stale, fresh, prev_stale, fell;
  logic [IDX_W-1:0]    last_sel;
  logic [CW-1:0]       drain_cnt;

  assign stale = status[STALE_LSB +: NUM_REGS];
  assign fresh = status[NEW_LSB +: NUM_REGS];
  assign fell  = prev_stale & ~stale;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_stale <= '0;
      last_sel   <= '0;
      drain_cnt  <= '0;
    end else begin
      prev_stale <= stale;
      last_sel   <= wr_sel;
      if (wr_en || !busy)        drain_cnt <= '0;
      else if (drain_cnt != '1)  drain_cnt <= drain_cnt + 1'b1;
    end
  end

  p_write_marks_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> stale[last_sel]);

  p_single_landing_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(fell) <= 1);

  p_landing_sets_fresh_r7: assert property (@(posedge clk) disable iff (rst)
    (fell & ~fresh) == '0);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !busy) |=> (fresh == '0));

  p_drain_bound_r10: assert property (@(posedge clk) disable iff (rst)
    int'(drain_cnt) <= BOUND);
endmodule

bind upd_shadow_seq upd_shadow_seq_chk #(
  .NUM_REGS    (NUM_REGS),
  .XFER_CYCLES (XFER_CYCLES),
  .STAT_W      (STAT_W),
  .STALE_LSB   (STALE_LSB),
  .NEW_LSB     (NEW_LSB),
  .IDX_W       (IDX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .stat_rd (stat_rd),
  .status  (status),
  .busy    (busy)
);

// File: tb/test_upd_shadow_seq.sv
module test_upd_shadow_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int DW   = 32;
  localparam int XFER = 4;
  localparam int IW   = 3;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, stat_rd = 1'b0;
  logic [IW-1:0] wr_sel = '0, slow_rd_sel;
  logic [DW-1:0] wr_data = '0, slow_rd_data;
  logic [31:0]   status;
  logic          busy;

  logic [IW-1:0] drv_sel = '0, mon_sel = '0;
  logic          mon_active = 1'b0;
  assign slow_rd_sel = mon_active ? mon_sel : drv_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  upd_shadow_seq #(.NUM_REGS(NREG), .DATA_W(DW), .XFER_CYCLES(XFER)) i_upd_shadow_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stat_rd(stat_rd), .slow_rd_sel(slow_rd_sel), .status(status),
    .busy(busy), .slow_rd_data(slow_rd_data)
  );

  int n_checks = 0, n_fail = 0;
  bit mon_en = 1'b0, finished = 1'b0;

  typedef struct packed { logic [IW-1:0] idx; logic [DW-1:0] data; } item_t;
  item_t exp_q[$];

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Monitor: a falling pending bit is a finished transfer.
  logic [NREG-1:0] prev_stale = '0;
  item_t pend_item;
  bit    pend = 1'b0;
  always @(negedge clk) begin : mon_blk
    logic [NREG-1:0] fell;
    int fidx;
    if (pend) begin
      check(slow_rd_data == pend_item.data, "R9 slow copy after landing",
            slow_rd_data, pend_item.data);
      pend = 1'b0;
      mon_active = 1'b0;
    end
    if (mon_en) begin
      fell = prev_stale & ~status[23:16];
      if (fell != '0) begin
        check($countones(fell) == 1, "R3 single landing per edge", $countones(fell), 1);
        fidx = 0;
        for (int i = NREG - 1; i >= 0; i--) if (fell[i]) fidx = i;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected transfer", fidx, 0);
        end else begin
          pend_item = exp_q.pop_front();
          check(fidx == int'(pend_item.idx), "R4 transfer order", fidx, pend_item.idx);
          mon_sel = IW'(fidx);
          mon_active = 1'b1;
          pend = 1'b1;
        end
      end
      prev_stale = status[23:16];
    end
  end

  task automatic wr(input int sel, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_sel = IW'(sel); wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Burst of up to six back-to-back writes into an idle block. The first
  // write is picked alone; the rest go lowest index first, latest data.
  task automatic burst(input int n, input int sels[6], input logic [DW-1:0] ds[6]);
    item_t it;
    it.idx = IW'(sels[0]); it.data = ds[0];
    exp_q.push_back(it);
    for (int r = 0; r < NREG; r++) begin
      bit found = 1'b0;
      logic [DW-1:0] last = '0;
      for (int k = 1; k < n; k++) if (sels[k] == r) begin found = 1'b1; last = ds[k]; end
      if (found) begin it.idx = IW'(r); it.data = last; exp_q.push_back(it); end
    end
    for (int k = 0; k < n; k++) wr(sels[k], ds[k]);
    idle();
  endtask

  initial begin
    int cyc;
    item_t it;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status == 32'h0, "R1 status after reset", status, 0);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    drv_sel = 3'd0; @(negedge clk);
    check(slow_rd_data == '0, "R1 slow copy 0 after reset", slow_rd_data, 0);
    drv_sel = 3'd7; @(negedge clk);
    check(slow_rd_data == '0, "R1 slow copy 7 after reset", slow_rd_data, 0);
    mon_en = 1'b1;

    // Single seconds write: R2, R5, R7, R8
    it.idx = 3'd7; it.data = 32'h5EC0_0001; exp_q.push_back(it);
    wr(7, 32'h5EC0_0001);
    check(status[23:16] == 8'h80, "R2 pending field after write", status[23:16], 8'h80);
    check(busy == 1'b1, "R8 busy while pending", busy, 1);
    idle();
    wait_n(3);
    check(status[23] == 1'b1, "R5 still pending one edge before landing", status[23], 1);
    wait_n(1);
    check(status[23] == 1'b0, "R5 pending clears on landing edge", status[23], 0);
    check(status[15] == 1'b1, "R7 refreshed bit set", status[15], 1);
    check(busy == 1'b0, "R8 busy low when nothing pending", busy, 0);
    wait_n(2);

    // Scrambled burst with a rewrite: R4, R6
    burst(6, '{5, 3, 0, 6, 1, 3},
          '{32'hA005, 32'hA003, 32'hA000, 32'hA006, 32'hA001, 32'hB003});
    wait_idle(cyc);
    wait_n(2);
    check(exp_q.size() == 0, "R6 rewrite gives one transfer", exp_q.size(), 0);
    check(status[15:8] == 8'hEB, "R7 refreshed field accumulates", status[15:8], 8'hEB);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    check(status[15:8] == 8'h00, "R7 status read clears refreshed", status[15:8], 0);

    // Descending burst and drain time: R4, R10
    burst(6, '{7, 6, 5, 4, 3, 2},
          '{32'hC007, 32'hC006, 32'hC005, 32'hC004, 32'hC003, 32'hC002});
    wait_idle(cyc);
    check(cyc + 1 <= NREG * (XFER + 1), "R10 drain bound", cyc + 1, NREG * (XFER + 1));
    wait_n(2);
    check(exp_q.size() == 0, "R4 all burst transfers seen", exp_q.size(), 0);

    // Write on the landing edge: R11
    it.idx = 3'd2; it.data = 32'hD00D_0002; exp_q.push_back(it);
    wr(2, 32'hD00D_0001);
    idle();
    wait_n(3);
    wr(2, 32'hD00D_0002);
    check(status[18] == 1'b1, "R11 pending kept on collision", status[18], 1);
    idle();
    wait_idle(cyc);
    wait_n(2);
    check(exp_q.size() == 0, "R11 newer value transferred", exp_q.size(), 0);

    // Landing coincident with status read: R7
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    it.idx = 3'd4; it.data = 32'hE004; exp_q.push_back(it);
    wr(4, 32'hE004);
    idle();
    wait_n(3);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    check(status[12] == 1'b1, "R7 landing wins over read clear", status[12], 1);
    wait_n(2);
    check(exp_q.size() == 0, "R9 last transfer seen", exp_q.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog expired: actual=0x0 expected=0x1");
      summary();
      $finish;
    end
  end
endmodule